// File: doc/BRIEF.md
# Descriptor Ring Address Generator

This block works out where in host memory the descriptors of a circular receive or transmit ring sit. Software programs the ring base, the ring length and a few mode bits through a small register-write port. The block keeps a 1-based countdown index that runs from the ring length down to 1 and then wraps. From that index it presents three descriptor addresses at once: the current slot, the next slot and the one after that. A fetch engine placed next to it can then prefetch ahead without doing any ring arithmetic of its own.

The spacing between descriptors is 8 bytes for the compact descriptor format and 16 bytes for the wide format. The block also turns a 24-bit-style buffer pointer read from a descriptor into a full 32-bit physical address. In the narrow addressing mode it takes the top byte from an upper-address control register. In the full 32-bit mode the pointer passes through unchanged. An advance strobe steps the index to the next slot. A ring length of zero is flagged as an error, and while it holds the block drives no address.

Top module: `ring_addr_gen`

## Requirements
- R1: After a synchronous active-low reset the ring length and the index both equal DEF_LEN (4), and the base, mode and upper-control registers are zero. The addresses are therefore 0x0, 0x8 and 0x10.
- R2: The current descriptor address is base + (length − w) × stride, taken modulo 2^32, where w is the wrapped current index. This value is also presented on `ring_idx`.
- R3: The stride is 16 bytes when the style field (mode register bits 7:0) is nonzero, and 8 bytes when that field is zero.
- R4: The next address uses index − 1 and the next-next address uses index − 2. Each of these, and the current index too, is wrapped by adding the ring length repeatedly until the value is at least 1.
- R5: An advance strobe replaces the index with the wrapped value of index − 1, so that 1 goes to the ring length. The new value is visible after the next rising clock edge.
- R6: In a cycle with neither an advance strobe nor a length or index write, the index and all three addresses hold their values.
- R7: The register selects are: 0 = base bits 15:0, 1 = base bits 31:16, 2 = ring length, 3 = mode (bits 7:0 style, bit 8 full 32-bit addressing), 4 = upper-address control, 5 = direct index load. Selects 6 and 7 are ignored.
- R8: While the ring length is 0, `ring_err` is 1, all three addresses read 0, and an advance strobe leaves the index unchanged.
- R9: The buffer output equals the input pointer when mode bit 8 is set. Otherwise it equals the pointer ORed with bits 15:8 of the upper-address control register placed at bits 31:24.
- R10: A write to the ring length loads the index with the same value. A length write or an index load in the same cycle as an advance strobe takes precedence over the strobe. Writes to other registers do not block an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| adv | input | 1 | Advance to the next ring slot |
| buf_ptr | input | 32 | Buffer pointer taken from a descriptor |
| buf_phys | output | 32 | Translated physical buffer address |
| desc_cur | output | 32 | Current descriptor address |
| desc_nxt | output | 32 | Next descriptor address |
| desc_nnx | output | 32 | Next-next descriptor address |
| ring_idx | output | 16 | Wrapped current index |
| ring_err | output | 1 | Ring length is zero |

## Verification
Several properties are checked on every cycle:
- In the error state all three addresses are zero.
- With the index away from the wrap point, neighbouring addresses differ by exactly one stride.
- The last slot maps to the base address.
- An advance moves the index down by one or wraps it from 1 to the length.
- An idle cycle leaves the index unchanged.
- Full 32-bit mode passes the buffer pointer straight through.

Other behaviour only the bench scenarios can show, by comparing every output against a behavioural model each cycle:
- repeated wrapping of small rings, with lengths 1 and 2 and a raw index of 0;
- the exact register map;
- the top-byte merge in narrow mode;
- modular wrap-around of the base address;
- write-versus-advance precedence.

// File: rtl/ring_pkg.sv
// Package: shared register-select codes and mode-field layout for the
// descriptor ring address generator. Assumes a 3-bit select bus.
package ring_pkg;

    typedef enum logic [2:0] {
        SEL_BASE_LO = 3'd0,
        SEL_BASE_HI = 3'd1,
        SEL_LEN     = 3'd2,
        SEL_MODE    = 3'd3,
        SEL_UCTL    = 3'd4,
        SEL_IDX     = 3'd5
    } cfg_sel_e;

    localparam int STYLE_W    = 8;   // width of the descriptor style field
    localparam int SIZE32_BIT = 8;   // mode bit selecting full 32-bit addressing
    localparam int UCTL_HI_W  = 8;   // upper-control bits merged into the pointer

endpackage

// File: rtl/ring_cfg_regs.sv
// Module: ring_cfg_regs
// Holds the ring base, ring length, mode and upper-address control registers.
// Assumes 16-bit writes; the base is split into two halves (low select first).
// Emits one-cycle load pulses for length and index writes.
module ring_cfg_regs
    import ring_pkg::*;
#(
    parameter int RW      = 16,
    parameter int DEF_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_sel,
    input  logic [RW-1:0]         cfg_wdata,
    output logic [2*RW-1:0]       ring_base,
    output logic [RW-1:0]         ring_len,
    output logic                  wide_desc,
    output logic                  size32_mode,
    output logic [UCTL_HI_W-1:0]  uctl_hi,
    output logic                  len_load,
    output logic                  idx_load
);

    cfg_sel_e                sel;
    logic [SIZE32_BIT:0]     mode_q;
    logic [UCTL_HI_W-1:0]    uctl_q;

    // Decode the select bus into the named register codes.
    always_comb sel = cfg_sel_e'(cfg_sel);

    // Register storage with synchronous reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_base <= '0;
            ring_len  <= RW'(DEF_LEN);
            mode_q    <= '0;
            uctl_q    <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_BASE_LO: ring_base[RW-1:0]    <= cfg_wdata;
                SEL_BASE_HI: ring_base[2*RW-1:RW] <= cfg_wdata;
                SEL_LEN:     ring_len             <= cfg_wdata;
                SEL_MODE:    mode_q               <= cfg_wdata[SIZE32_BIT:0];
                SEL_UCTL:    uctl_q               <= cfg_wdata[RW-1:RW-UCTL_HI_W];
                default:     ;
            endcase
        end
    end

    // Field extraction and load pulses toward the index counter.
    always_comb begin
        wide_desc   = |mode_q[STYLE_W-1:0];
        size32_mode = mode_q[SIZE32_BIT];
        uctl_hi     = uctl_q;
        len_load    = cfg_we && (sel == SEL_LEN);
        idx_load    = cfg_we && (sel == SEL_IDX);
    end

endmodule

// File: rtl/ring_slot.sv
// Module: ring_slot
// Wraps (index - OFS) into 1..len by repeated addition of len and turns it
// into a descriptor address. Assumes index >= 0, so at most OFS+1 additions
// are needed; with len = 0 the value is left unwrapped (caller gates it).
module ring_slot #(
    parameter int RW  = 16,
    parameter int OFS = 0
) (
    input  logic [RW-1:0]   idx,
    input  logic [RW-1:0]   len,
    input  logic [2*RW-1:0] base,
    input  logic            wide,
    output logic [RW-1:0]   widx,
    output logic [2*RW-1:0] addr
);

    localparam int AW = 2 * RW;
    localparam int SW = RW + 3;
    localparam logic signed [SW-1:0] OFS_S = SW'(OFS);
    localparam logic signed [SW-1:0] ONE_S = SW'(1);

    logic signed [SW-1:0] v;
    logic [AW-1:0]        span;

    // Offset the index and fold it back into the 1-based ring range.
    always_comb begin
        v = $signed({3'b000, idx}) - OFS_S;
        for (int i = 0; i <= OFS; i++) begin
            if (v < ONE_S) v = v + $signed({3'b000, len});
        end
        widx = v[RW-1:0];
    end

    // Scale the distance from the ring top by the stride and add the base.
    always_comb begin
        span = AW'(len) - AW'(widx);
        addr = base + (wide ? (span << 4) : (span << 3));
    end

endmodule

// File: rtl/ring_idx_ctr.sv
// Module: ring_idx_ctr
// Raw countdown index register. Length or index writes load it directly and
// win over the advance strobe; an advance takes the pre-wrapped next index.
// Assumes the caller supplies the wrapped index-1 value.
module ring_idx_ctr #(
    parameter int RW      = 16,
    parameter int DEF_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          len_load,
    input  logic          idx_load,
    input  logic [RW-1:0] load_val,
    input  logic          adv,
    input  logic          ring_err,
    input  logic [RW-1:0] next_idx,
    output logic [RW-1:0] idx_q
);

    // Index update: reset, load, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                     idx_q <= RW'(DEF_LEN);
        else if (len_load || idx_load)  idx_q <= load_val;
        else if (adv && !ring_err)      idx_q <= next_idx;
    end

endmodule

// File: rtl/ring_buf_xlate.sv
// Module: ring_buf_xlate
// Expands a descriptor buffer pointer to a physical address. In narrow mode
// the top byte comes from the upper-address control register (ORed in).
module ring_buf_xlate #(
    parameter int AW = 32,
    parameter int HW = 8
) (
    input  logic [AW-1:0] ptr,
    input  logic          size32,
    input  logic [HW-1:0] hi_byte,
    output logic [AW-1:0] phys
);

    // Pass through in full mode, merge the high byte otherwise.
    always_comb phys = size32 ? ptr : (ptr | {hi_byte, {(AW-HW){1'b0}}});

endmodule

// File: rtl/ring_addr_gen.sv
// Module: ring_addr_gen (top)
// Descriptor ring address generator: config registers, countdown index and
// three parallel slot calculators (current, next, next-next), plus buffer
// pointer translation. Addresses are combinational from registered state.
module ring_addr_gen
    import ring_pkg::*;
#(
    parameter int RW      = 16,
    parameter int DEF_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [RW-1:0]     cfg_wdata,
    input  logic              adv,
    input  logic [2*RW-1:0]   buf_ptr,
    output logic [2*RW-1:0]   buf_phys,
    output logic [2*RW-1:0]   desc_cur,
    output logic [2*RW-1:0]   desc_nxt,
    output logic [2*RW-1:0]   desc_nnx,
    output logic [RW-1:0]     ring_idx,
    output logic              ring_err
);

    localparam int AW    = 2 * RW;
    localparam int SLOTS = 3;

    logic [AW-1:0]        ring_base;
    logic [RW-1:0]        ring_len;
    logic                 wide_desc;
    logic                 size32_mode;
    logic [UCTL_HI_W-1:0] uctl_hi;
    logic                 len_load;
    logic                 idx_load;
    logic [RW-1:0]        idx_q;
    logic [AW-1:0]        slot_addr [SLOTS];
    logic [RW-1:0]        slot_widx [SLOTS];
    logic                 slot_unused;

    ring_cfg_regs #(.RW(RW), .DEF_LEN(DEF_LEN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ring_base  (ring_base),
        .ring_len   (ring_len),
        .wide_desc  (wide_desc),
        .size32_mode(size32_mode),
        .uctl_hi    (uctl_hi),
        .len_load   (len_load),
        .idx_load   (idx_load)
    );

    // Error when the ring has no slots.
    always_comb ring_err = (ring_len == '0);

    ring_idx_ctr #(.RW(RW), .DEF_LEN(DEF_LEN)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_load (len_load),
        .idx_load (idx_load),
        .load_val (cfg_wdata),
        .adv      (adv),
        .ring_err (ring_err),
        .next_idx (slot_widx[1]),
        .idx_q    (idx_q)
    );

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        ring_slot #(.RW(RW), .OFS(k)) u_slot (
            .idx  (idx_q),
            .len  (ring_len),
            .base (ring_base),
            .wide (wide_desc),
            .widx (slot_widx[k]),
            .addr (slot_addr[k])
        );
    end

    // The next-next wrapped index is only needed inside its slot.
    always_comb slot_unused = ^slot_widx[2];

    // Gate the addresses while the ring is invalid.
    always_comb begin
        desc_cur = ring_err ? '0 : slot_addr[0];
        desc_nxt = ring_err ? '0 : slot_addr[1];
        desc_nnx = ring_err ? '0 : slot_addr[2];
        ring_idx = slot_widx[0];
    end

    ring_buf_xlate #(.AW(AW), .HW(UCTL_HI_W)) u_xlate (
        .ptr     (buf_ptr),
        .size32  (size32_mode),
        .hi_byte (uctl_hi),
        .phys    (buf_phys)
    );

endmodule

// File: rtl/ring_addr_gen_chk.sv
// Module: ring_addr_gen_chk
// Property checker for ring_addr_gen, attached by bind below. Observes ports
// plus the base, length and mode fields held inside the top.
module ring_addr_gen_chk
    import ring_pkg::*;
#(
    parameter int RW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic              adv,
    input logic [2*RW-1:0]   buf_ptr,
    input logic [2*RW-1:0]   buf_phys,
    input logic [2*RW-1:0]   desc_cur,
    input logic [2*RW-1:0]   desc_nxt,
    input logic [2*RW-1:0]   desc_nnx,
    input logic [RW-1:0]     ring_idx,
    input logic              ring_err,
    input logic [2*RW-1:0]   ring_base,
    input logic [RW-1:0]     ring_len,
    input logic              wide_desc,
    input logic              size32_mode
);

    logic          ldw;
    logic [2*RW-1:0] stride;

    // Detect writes that reload the index, and the expected stride.
    always_comb begin
        ldw    = cfg_we && ((cfg_sel == SEL_LEN) || (cfg_sel == SEL_IDX));
        stride = wide_desc ? (2*RW)'(16) : (2*RW)'(8);
    end

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ring_err |-> (desc_cur == '0 && desc_nxt == '0 && desc_nnx == '0)); // R8
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_err && adv && !cfg_we) |=> $stable(ring_idx)); // R8
    AST_CUR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_err && ring_idx == ring_len) |-> desc_cur == ring_base); // R2
    AST_STRIDE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_err && ring_idx >= 3 && ring_idx <= ring_len)
        |-> (desc_nxt == desc_cur + stride && desc_nnx == desc_nxt + stride)); // R3
    AST_NXT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_err && ring_idx == 1) |-> desc_nxt == ring_base); // R4
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ring_err && !ldw && ring_idx > 1) |=> ring_idx == $past(ring_idx) - 1'b1); // R5
    AST_ADV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ring_err && !ldw && ring_idx == 1) |=> ring_idx == $past(ring_len)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cfg_we) |=> ($stable(ring_idx) && $stable(desc_cur))); // R6
    AST_XLATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        size32_mode |-> buf_phys == buf_ptr); // R9

endmodule

bind ring_addr_gen ring_addr_gen_chk #(.RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .adv        (adv),
    .buf_ptr    (buf_ptr),
    .buf_phys   (buf_phys),
    .desc_cur   (desc_cur),
    .desc_nxt   (desc_nxt),
    .desc_nnx   (desc_nnx),
    .ring_idx   (ring_idx),
    .ring_err   (ring_err),
    .ring_base  (ring_base),
    .ring_len   (ring_len),
    .wide_desc  (wide_desc),
    .size32_mode(size32_mode)
);

// File: tb/ring_addr_gen_bench.sv
`timescale 1ns/1ps
// Bench: behavioural model (integers) updated at each rising edge, every
// output compared at the following falling edge.
module ring_addr_gen_bench;

    localparam int DEF_LEN = 4;

    logic        clk = 1'b0;
    logic        b_rn = 1'b0, b_we = 1'b0, b_adv = 1'b0;
    logic [2:0]  b_sel = '0;
    logic [15:0] b_wd = '0;
    logic [31:0] b_ptr = '0;
    logic [31:0] buf_phys, desc_cur, desc_nxt, desc_nnx;
    logic [15:0] ring_idx;
    logic        ring_err;

    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;
    string       phase = "R1";

    int          m_len, m_idx, m_mode, m_ctl;
    logic [31:0] m_base;

    always #4 clk = ~clk;

    ring_addr_gen u_ring_addr_gen (
        .clk(clk), .rst_n(b_rn), .cfg_we(b_we), .cfg_sel(b_sel), .cfg_wdata(b_wd),
        .adv(b_adv), .buf_ptr(b_ptr), .buf_phys(buf_phys), .desc_cur(desc_cur),
        .desc_nxt(desc_nxt), .desc_nnx(desc_nnx), .ring_idx(ring_idx), .ring_err(ring_err)
    );

    function automatic int mwrap(int v, int len);
        int r = v;
        if (len <= 0) return v;
        while (r < 1) r += len;
        return r;
    endfunction

    function automatic logic [31:0] maddr(int off);
        logic [31:0] d;
        if (m_len == 0) return 32'h0;
        d = 32'(m_len - mwrap(m_idx - off, m_len));
        d = ((m_mode & 'hff) != 0) ? (d << 4) : (d << 3);
        return m_base + d;
    endfunction

    task automatic cmp(string what, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %h expected %h", tag, phase, what, act, exp);
        end
    endtask

    task automatic model_step();
        int old_len = m_len;
        bit ld = 0;
        if (!b_rn) begin
            m_len = DEF_LEN; m_idx = DEF_LEN; m_base = '0; m_mode = 0; m_ctl = 0;
        end else begin
            if (b_we) case (b_sel)
                3'd0: m_base[15:0]  = b_wd;
                3'd1: m_base[31:16] = b_wd;
                3'd2: begin m_len = int'(b_wd); m_idx = int'(b_wd); ld = 1; end
                3'd3: m_mode = int'(b_wd);
                3'd4: m_ctl = int'(b_wd);
                3'd5: begin m_idx = int'(b_wd); ld = 1; end
                default: ;
            endcase
            if (b_adv && !ld && old_len != 0) m_idx = mwrap(m_idx - 1, old_len);
        end
    endtask

    task automatic cyc(bit rn, bit we, logic [2:0] s, logic [15:0] d, bit a, logic [31:0] p);
        logic [31:0] exp_buf;
        b_rn = rn; b_we = we; b_sel = s; b_wd = d; b_adv = a; b_ptr = p;
        @(posedge clk);
        model_step();
        @(negedge clk);
        exp_buf = m_mode[8] ? b_ptr : (b_ptr | (32'(m_ctl & 'hff00) << 16));
        cmp("desc_cur", "R2", desc_cur, maddr(0));
        cmp("desc_nxt", "R4", desc_nxt, maddr(1));
        cmp("desc_nnx", "R4", desc_nnx, maddr(2));
        cmp("ring_idx", "R5", 32'(ring_idx), 32'(16'(mwrap(m_idx, m_len))));
        cmp("ring_err", "R8", 32'(ring_err), 32'(m_len == 0));
        cmp("buf_phys", "R9", buf_phys, exp_buf);
    endtask

    task automatic wr(logic [2:0] s, logic [15:0] d);
        cyc(1, 1, s, d, 0, b_ptr);
    endtask

    task automatic step(bit a);
        cyc(1, 0, 3'd0, 16'h0, a, b_ptr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        phase = "R1";                       // reset state: 0x0, 0x8, 0x10
        cyc(0, 0, 3'd0, 16'h0, 0, 32'h0);
        cyc(0, 1, 3'd2, 16'h9, 1, 32'h0);   // reset beats write and advance
        step(0);
        phase = "R2";                       // base and length programming
        wr(3'd0, 16'h1000); wr(3'd1, 16'h0002); wr(3'd2, 16'd6);
        step(0);
        phase = "R5";                       // advance through a wrap
        for (int i = 0; i < 8; i++) step(1);
        phase = "R3";                       // wide stride
        wr(3'd3, 16'h0002);
        for (int i = 0; i < 4; i++) step(1);
        wr(3'd3, 16'h0000);
        step(1);
        phase = "R4";                       // wrap of small rings and index 0
        wr(3'd5, 16'd0); step(0); step(1);
        wr(3'd2, 16'd1); step(0); step(1); wr(3'd5, 16'd0); step(1);
        wr(3'd2, 16'd2); step(1); step(1); wr(3'd5, 16'd0); step(0);
        phase = "R6";                       // idle hold
        wr(3'd2, 16'd5); step(1);
        for (int i = 0; i < 3; i++) step(0);
        phase = "R8";                       // zero length
        wr(3'd2, 16'd0); step(1); step(1); wr(3'd5, 16'd3); step(1);
        wr(3'd2, 16'd3); step(1);
        phase = "R9";                       // buffer translation
        wr(3'd4, 16'hAB12);
        cyc(1, 0, 3'd0, 16'h0, 0, 32'h0034_5678);
        cyc(1, 0, 3'd0, 16'h0, 0, 32'h1234_5678);
        wr(3'd3, 16'h0100);
        cyc(1, 0, 3'd0, 16'h0, 0, 32'h1234_5678);
        wr(3'd3, 16'h0000);
        phase = "R10";                      // write precedence over advance
        cyc(1, 1, 3'd2, 16'd7, 1, b_ptr);
        cyc(1, 1, 3'd5, 16'd2, 1, b_ptr);
        cyc(1, 1, 3'd0, 16'h0040, 1, b_ptr);
        cyc(1, 1, 3'd4, 16'h5500, 1, b_ptr);
        step(1);
        phase = "R7";                       // register map, base wrap, dead selects
        wr(3'd1, 16'hFFFF); wr(3'd0, 16'hFFF8); wr(3'd5, 16'd1);
        step(0);
        wr(3'd6, 16'h1234); wr(3'd7, 16'hFFFF);
        step(1); step(1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule